// File: doc/BRIEF.md
# Serial Control Frame Receiver

This block takes a three-wire control link (an enable line, a serial clock and a data line) and turns it into a committed control word for an audio processing chain. All three lines are asynchronous to the system clock. The block synchronises them and finds their edges. While enable is high it shifts in one bit on each rising edge of the serial clock. A frame opens with an 8-bit device address and carries 96 payload bits after it.

When enable falls, the block checks two things: that exactly 104 serial clocks arrived, and that the address matches the device address. If both hold, the whole payload moves into the active control register at once and a strobe pulses for one system clock. Otherwise the frame is dropped.

Several fields of the active word are also brought out in decoded form: the source selector, the two input gains, the two volume bytes, the four tone nibbles and the four output attenuation levels. Downstream logic can then use them without knowing where they sit in the word.

Top module: `scf_rx`

## Requirements
- R1: Frame bit n (n counted from 0 at the first serial clock after enable rises) is the address bit n for n < 8, and payload bit n-8 otherwise. On commit, payload bit k lands at `ctrl_word[k]`. Data is sampled on the rising edge of `ser_clk`.
- R2: When `ser_en` falls after exactly 104 serial clocks with address byte 0x81 (first bit 1, eighth bit 1, all others 0), the payload is committed and `commit` is high for exactly one system clock.
- R3: A frame whose address byte differs from 0x81 produces no `commit` and leaves `ctrl_word` unchanged.
- R4: A frame of 103 or 105 serial clocks produces no `commit` and leaves `ctrl_word` unchanged. `ctrl_word` never changes in a cycle where `commit` is low.
- R5: `in_sel` decodes `ctrl_word[2:0]` (bit 0 least significant). Code c in 1..4 sets only bit c-1. Codes 0, 5, 6 and 7 give all zeros.
- R6: `gain_l` is `ctrl_word[7:3]` and `gain_r` is `ctrl_word[12:8]`, each read as an unsigned number with its lowest bit first. Codes above 18 saturate to 18.
- R7: `vol_l` = `ctrl_word[20:13]` and `vol_r` = `ctrl_word[28:21]`. `treble_l` = `ctrl_word[32:29]` and `treble_r` = `ctrl_word[36:33]`. `bass_l` = `ctrl_word[40:37]` and `bass_r` = `ctrl_word[44:41]`.
- R8: `fade_lvl[4k+3:4k]` is `ctrl_word[45+6k +: 4]`, with k = 0..3 for left front, left rear, right front and right rear. The upper two bits of each 6-bit field have no effect.
- R9: While `rst` is high and in the first cycle after it, `ctrl_word` is zero and `commit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Frame enable; high while a frame is being sent |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| ctrl_word | output | 96 | Active committed payload |
| commit | output | 1 | One-cycle pulse when a frame is committed |
| in_sel | output | 4 | One-hot source selection |
| gain_l | output | 5 | Left input gain step, 0..18 |
| gain_r | output | 5 | Right input gain step, 0..18 |
| vol_l | output | 8 | Left volume code |
| vol_r | output | 8 | Right volume code |
| treble_l | output | 4 | Left treble code |
| treble_r | output | 4 | Right treble code |
| bass_l | output | 4 | Left bass code |
| bass_r | output | 4 | Right bass code |
| fade_lvl | output | 16 | Four packed 4-bit attenuation levels |

## Verification
Frames with a correct address and length carry payloads that differ at both ends of the word and in every decoded field. Such frames show whether the bit order and the field positions are right. Frames with a wrong address (one extra bit set, or the first bit cleared), and frames one clock short or one clock long, show whether the address compare and the exact-length test each reject a frame on their own. A sweep over all eight selector codes, paired with gain codes that cross 18, separates the one-hot decode and the saturation point from their neighbours.

// File: rtl/scf_pkg.sv
package scf_pkg;

    localparam int ADDR_BITS = 8;
    localparam int DATA_BITS = 96;
    localparam logic [ADDR_BITS-1:0] DEV_ADDR_DEF = 8'h81;

    // payload field positions
    localparam int SEL_LSB    = 0;
    localparam int SEL_W      = 3;
    localparam int GAIN_W     = 5;
    localparam int GAIN_L_LSB = 3;
    localparam int GAIN_R_LSB = 8;
    localparam int GAIN_MAX   = 18;
    localparam int VOL_W      = 8;
    localparam int VOL_L_LSB  = 13;
    localparam int VOL_R_LSB  = 21;
    localparam int TONE_W     = 4;
    localparam int TRE_L_LSB  = 29;
    localparam int TRE_R_LSB  = 33;
    localparam int BAS_L_LSB  = 37;
    localparam int BAS_R_LSB  = 41;
    localparam int FADE_LSB   = 45;
    localparam int FADE_FLD_W = 6;
    localparam int FADE_LVL_W = 4;
    localparam int FADE_N     = 4;
    localparam int SRC_N      = 4;

    typedef struct packed {
        logic [SRC_N-1:0]             in_sel;
        logic [GAIN_W-1:0]            gain_l;
        logic [GAIN_W-1:0]            gain_r;
        logic [VOL_W-1:0]             vol_l;
        logic [VOL_W-1:0]             vol_r;
        logic [TONE_W-1:0]            treble_l;
        logic [TONE_W-1:0]            treble_r;
        logic [TONE_W-1:0]            bass_l;
        logic [TONE_W-1:0]            bass_r;
        logic [FADE_N*FADE_LVL_W-1:0] fade;
    } fields_t;

    function automatic logic [GAIN_W-1:0] gain_sat(input logic [GAIN_W-1:0] code);
        return (int'(code) > GAIN_MAX) ? GAIN_W'(GAIN_MAX) : code;
    endfunction

endpackage

// File: rtl/scf_sync.sv
module scf_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/scf_frame.sv
module scf_frame #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 96,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h81
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_s,
    input  logic              sck_s,
    input  logic              dat_s,
    output logic [DATA_W-1:0] word,
    output logic              strobe
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic [FRAME_W-1:0] shadow;
    logic [CNT_W-1:0]   cnt;
    logic               en_d, sck_d;
    logic               en_rise, en_fall, sck_rise, frame_ok;

    assign en_rise  = en_s & ~en_d;
    assign en_fall  = ~en_s & en_d;
    assign sck_rise = sck_s & ~sck_d & en_s;
    assign frame_ok = (cnt == CNT_FULL) && (shadow[ADDR_W-1:0] == DEV_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d   <= 1'b0;
            sck_d  <= 1'b0;
            cnt    <= '0;
            shadow <= '0;
            word   <= '0;
            strobe <= 1'b0;
        end else begin
            en_d   <= en_s;
            sck_d  <= sck_s;
            strobe <= 1'b0;
            if (en_rise) begin
                cnt <= '0;
            end else if (sck_rise) begin
                shadow <= {dat_s, shadow[FRAME_W-1:1]};
                if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
            end
            if (en_fall && frame_ok) begin
                word   <= shadow[FRAME_W-1:ADDR_W];
                strobe <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/scf_decode.sv
module scf_decode
    import scf_pkg::*;
#(
    parameter int DATA_W = 96
) (
    input  logic [DATA_W-1:0] word,
    output fields_t           f
);
    logic [SEL_W-1:0] sel_code;
    assign sel_code = word[SEL_LSB +: SEL_W];

    always_comb begin
        f          = '0;
        for (int s = 0; s < SRC_N; s++)
            f.in_sel[s] = (int'(sel_code) == s + 1);
        f.gain_l   = gain_sat(word[GAIN_L_LSB +: GAIN_W]);
        f.gain_r   = gain_sat(word[GAIN_R_LSB +: GAIN_W]);
        f.vol_l    = word[VOL_L_LSB +: VOL_W];
        f.vol_r    = word[VOL_R_LSB +: VOL_W];
        f.treble_l = word[TRE_L_LSB +: TONE_W];
        f.treble_r = word[TRE_R_LSB +: TONE_W];
        f.bass_l   = word[BAS_L_LSB +: TONE_W];
        f.bass_r   = word[BAS_R_LSB +: TONE_W];
        for (int k = 0; k < FADE_N; k++)
            f.fade[k*FADE_LVL_W +: FADE_LVL_W] = word[FADE_LSB + k*FADE_FLD_W +: FADE_LVL_W];
    end
endmodule

// File: rtl/scf_rx.sv
module scf_rx
    import scf_pkg::*;
#(
    parameter int ADDR_W = ADDR_BITS,
    parameter int DATA_W = DATA_BITS,
    parameter logic [ADDR_W-1:0] DEV_ADDR = DEV_ADDR_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ser_en,
    input  logic                         ser_clk,
    input  logic                         ser_dat,
    output logic [DATA_W-1:0]            ctrl_word,
    output logic                         commit,
    output logic [SRC_N-1:0]             in_sel,
    output logic [GAIN_W-1:0]            gain_l,
    output logic [GAIN_W-1:0]            gain_r,
    output logic [VOL_W-1:0]             vol_l,
    output logic [VOL_W-1:0]             vol_r,
    output logic [TONE_W-1:0]            treble_l,
    output logic [TONE_W-1:0]            treble_r,
    output logic [TONE_W-1:0]            bass_l,
    output logic [TONE_W-1:0]            bass_r,
    output logic [FADE_N*FADE_LVL_W-1:0] fade_lvl
);
    logic [2:0] sync_q;
    fields_t    fld;

    scf_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_en, ser_clk, ser_dat}),
        .q   (sync_q)
    );

    scf_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .en_s   (sync_q[2]),
        .sck_s  (sync_q[1]),
        .dat_s  (sync_q[0]),
        .word   (ctrl_word),
        .strobe (commit)
    );

    scf_decode #(.DATA_W(DATA_W)) u_dec (
        .word (ctrl_word),
        .f    (fld)
    );

    assign in_sel   = fld.in_sel;
    assign gain_l   = fld.gain_l;
    assign gain_r   = fld.gain_r;
    assign vol_l    = fld.vol_l;
    assign vol_r    = fld.vol_r;
    assign treble_l = fld.treble_l;
    assign treble_r = fld.treble_r;
    assign bass_l   = fld.bass_l;
    assign bass_r   = fld.bass_r;
    assign fade_lvl = fld.fade;
endmodule

// File: rtl/scf_rx_chk.sv
module scf_rx_chk #(
    parameter int DATA_W = 96
) (
    input logic              clk,
    input logic              rst,
    input logic              commit,
    input logic [DATA_W-1:0] ctrl_word,
    input logic [3:0]        in_sel,
    input logic [4:0]        gain_l,
    input logic [4:0]        gain_r
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);                                      // R2

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !commit |-> $stable(ctrl_word));                          // R4

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_sel));                                        // R5

    AST_GAIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (gain_l <= 5'd18) && (gain_r <= 5'd18));                  // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (ctrl_word == '0) && !commit);                  // R9
endmodule

bind scf_rx scf_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit),
    .ctrl_word (ctrl_word),
    .in_sel    (in_sel),
    .gain_l    (gain_l),
    .gain_r    (gain_r)
);

// File: tb/scf_rx_test.sv
`timescale 1ns/1ps
module scf_rx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [95:0] ctrl_word;
    logic        commit;
    logic [3:0]  in_sel;
    logic [4:0]  gain_l, gain_r;
    logic [7:0]  vol_l, vol_r;
    logic [3:0]  treble_l, treble_r, bass_l, bass_r;
    logic [15:0] fade_lvl;

    int checks = 0, fails = 0;
    int cycles = 0;
    bit done = 0;
    logic [95:0] model = '0;

    always #2.5 clk = ~clk;

    scf_rx uut (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ctrl_word(ctrl_word), .commit(commit), .in_sel(in_sel),
        .gain_l(gain_l), .gain_r(gain_r), .vol_l(vol_l), .vol_r(vol_r),
        .treble_l(treble_l), .treble_r(treble_r), .bass_l(bass_l), .bass_r(bass_r),
        .fade_lvl(fade_lvl)
    );

    localparam int NV = 7;
    localparam logic [7:0]  V_ADR [NV] = '{8'h81, 8'h80, 8'h81, 8'h81, 8'h81, 8'h83, 8'h81};
    localparam int          V_LEN [NV] = '{104, 104, 103, 105, 104, 104, 104};
    localparam logic [95:0] V_PAY [NV] = '{
        96'h5A5A_A5A5_0F0F_F0F0_3C3C_C3C1,
        96'h1111_2222_3333_4444_5555_6666,
        96'h7777_8888_9999_AAAA_BBBB_CCCC,
        96'hDDDD_EEEE_FFFF_0000_1234_5678,
        96'hFFFF_0000_1234_5678_9ABC_DEF2,
        96'h0F1E_2D3C_4B5A_6978_8796_A5B4,
        96'h8000_0000_0000_0000_0000_0003};

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] e_sel(input logic [95:0] w);
        case (w[2:0])
            3'd1: return 4'b0001;
            3'd2: return 4'b0010;
            3'd3: return 4'b0100;
            3'd4: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [4:0] e_gain(input logic [4:0] c);
        return (c > 5'd18) ? 5'd18 : c;
    endfunction

    task automatic check_fields(input logic [95:0] e);
        logic [15:0] ef;
        for (int k = 0; k < 4; k++) ef[4*k +: 4] = e[45 + 6*k +: 4];
        chk(ctrl_word == e, "R1 word", ctrl_word, e);
        chk(in_sel == e_sel(e), "R5 in_sel", 96'(in_sel), 96'(e_sel(e)));
        chk(gain_l == e_gain(e[7:3]) && gain_r == e_gain(e[12:8]), "R6 gain",
            96'({gain_l, gain_r}), 96'({e_gain(e[7:3]), e_gain(e[12:8])}));
        chk({vol_l, vol_r, treble_l, treble_r, bass_l, bass_r} ==
            {e[20:13], e[28:21], e[32:29], e[36:33], e[40:37], e[44:41]}, "R7 vol/tone",
            96'({vol_l, vol_r, treble_l, treble_r, bass_l, bass_r}),
            96'({e[20:13], e[28:21], e[32:29], e[36:33], e[40:37], e[44:41]}));
        chk(fade_lvl == ef, "R8 fade", 96'(fade_lvl), 96'(ef));
    endtask

    task automatic send(input logic [7:0] a, input logic [95:0] p, input int len, output int pulses);
        ser_en = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            ser_dat = (i < 8) ? a[i] : ((i < 104) ? p[i-8] : 1'b0);
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        ser_en = 1'b0;
        pulses = 0;
        repeat (12) begin
            @(negedge clk);
            if (commit) pulses++;
        end
    endtask

    task automatic run_frame(input logic [7:0] a, input logic [95:0] p, input int len, input string tag);
        int pulses;
        bit good;
        good = (a == 8'h81) && (len == 104);
        send(a, p, len, pulses);
        if (good) model = p;
        chk(pulses == (good ? 1 : 0), good ? "R2 commit pulse" : (a != 8'h81 ? "R3 reject" : "R4 reject"),
            96'(pulses), 96'(good ? 1 : 0));
        check_fields(model);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(ctrl_word == '0 && commit == 1'b0, "R9 in reset", ctrl_word, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(ctrl_word == '0 && commit == 1'b0, "R9 after reset", ctrl_word, '0);
        check_fields('0);

        // table walk: R1..R8
        for (int v = 0; v < NV; v++) run_frame(V_ADR[v], V_PAY[v], V_LEN[v], "table");

        // selector sweep with gain codes crossing the limit: R5, R6
        for (int s = 0; s < 8; s++) begin
            logic [95:0] p;
            p = 96'h0;
            p[2:0]  = 3'(s);
            p[7:3]  = 5'(15 + 2*s);
            p[12:8] = 5'(31 - 2*s);
            run_frame(8'h81, p, 104, "sweep");
        end

        // upper fader bits have no effect: R8
        run_frame(8'h81, {27'h0, 6'b110101, 6'b111010, 6'b100000, 6'b010011, 45'h0}, 104, "fade");

        // reset clears a committed word: R9
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(ctrl_word == '0, "R9 re-reset", ctrl_word, '0);
        rst = 1'b0;
        model = '0;
        @(negedge clk);
        chk(ctrl_word == '0 && commit == 1'b0, "R9 after re-reset", ctrl_word, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule